// File: doc/BRIEF.md
# System Controller Register Bank

This block is the control and status register bank of a small SoC. A host reaches it through a simple word-wide register port. It samples the GPIO input pins and drives the GPIO output pins. It holds a GPIO interrupt mask, a debug scratch word with a sticky lock, and a command port for a reconfiguration engine. It also returns fixed words for the clock frequency, the capability flags and the system identity.

Two identical interval timers sit at fixed windows in the map. Each timer has its own interrupt line. Two writes have side effects beyond storage:
- a write to the identity word raises a one-cycle system reset request;
- a shutdown command code written to the command port raises a one-cycle shutdown request.

Those two pulses leave the block for the chip's reset and power logic.

The host presents a byte address. Bits [6:2] select one of 32 word slots and the two low bits are ignored. A read is answered one cycle later, with `rd_valid_o` high for that cycle.

Top module: `soc_ctrl_regs`

## Requirements
- R1: Word slot = byte address >> 2 (low two bits ignored). Read data appears with `rd_valid_o` one cycle after `rd_en_i`. Slots 3, 7, 11 to 15, 17 to 19 and 22 to 28 read as zero, and writes to them change no readable word.
- R2: After reset the bank reads as follows:
  - slot 31 (identity): 0x10014D31
  - slot 29 (clock frequency): 80000000
  - slot 30 (capabilities): 0
  - slot 16 (command port): 1, which is the ready bit 0
  - slot 0 (sampled GPIO inputs): the pins, which equal the strap value 1 when the pins are held at 1
  - all other mapped words: 0
- R3: The lock flag at slot 21 becomes 1 on any write, whatever the data, and stays 1 until reset.
- R4: The scratch word at slot 20 stores written data while the lock is 0 and ignores writes once the lock is 1.
- R5: A write to slot 31 gives exactly one cycle of `sys_reset_req_o` and leaves the identity word unchanged.
- R6: A write to slot 16 whose bits [15:0] equal 0x000E gives exactly one cycle of `shutdown_req_o`. Other data gives no pulse, and slot 16 always reads 1.
- R7: Writes to slots 0, 29 and 30 are ignored.
- R8: Each timer occupies three slots: control at base+0, compare at base+1 and counter at base+2. Timer 0 has base 4 and timer 1 has base 8. The control word uses bit 0 for enable and bit 1 for auto-restart. While enabled, the counter rises by one per cycle. On the cycle the counter equals compare, the timer pulses its interrupt for one cycle and the counter returns to 0. A stopped counter holds a written value.
- R9: Without auto-restart, a hit clears the enable bit, so exactly one interrupt pulse occurs and the counter rests at 0.
- R10: With auto-restart set, interrupt pulses repeat every compare+1 cycles.
- R11: Slots 1 (GPIO output) and 2 (interrupt mask) are read/write, truncated to the GPIO width. `gpio_out_o` follows slot 1.
- R12: When a GPIO input bit whose mask bit is 1 changes, `gpio_irq_o` pulses for one cycle. Changes on masked-off bits give no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe |
| addr_i | input | 7 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, registered |
| rd_valid_o | output | 1 | Read data valid |
| gpio_in_i | input | 8 | GPIO input pins |
| gpio_out_o | output | 8 | GPIO output pins |
| gpio_irq_o | output | 1 | GPIO change interrupt pulse |
| tmr_irq_o | output | 2 | Timer interrupt pulses, one bit per timer |
| sys_reset_req_o | output | 1 | System reset request pulse |
| shutdown_req_o | output | 1 | Shutdown / reconfigure request pulse |

## Verification
The bench targets three classes of bug:
- **Side-effect slots.** It writes zero to the lock and expects it to read 1, so a design that stores the data fails. It writes the identity word and expects the stored value unchanged plus a single pulse, so a design that overwrites the ID or holds the request fails.
- **Timer edges.** It measures the spacing of auto-restart pulses, which catches off-by-one compare logic. It checks that a one-shot timer fires exactly once and then reads disabled, which catches a timer that keeps running.
- **Masking and aliasing.** It checks that masked GPIO changes raise no interrupt, that the shutdown code is matched on its low half only, and that addresses with nonzero low bits alias onto the right word.

// File: rtl/soc_ctrl_pkg.sv
package soc_ctrl_pkg;

  localparam int unsigned DATA_W  = 32;
  localparam int unsigned IDX_W   = 5;

  localparam logic [IDX_W-1:0] SLOT_GPIO_IN  = 5'd0;
  localparam logic [IDX_W-1:0] SLOT_GPIO_OUT = 5'd1;
  localparam logic [IDX_W-1:0] SLOT_GPIO_MSK = 5'd2;
  localparam logic [IDX_W-1:0] SLOT_CMD      = 5'd16;
  localparam logic [IDX_W-1:0] SLOT_SCRATCH  = 5'd20;
  localparam logic [IDX_W-1:0] SLOT_LOCK     = 5'd21;
  localparam logic [IDX_W-1:0] SLOT_FREQ     = 5'd29;
  localparam logic [IDX_W-1:0] SLOT_CAPS     = 5'd30;
  localparam logic [IDX_W-1:0] SLOT_ID       = 5'd31;

  localparam int unsigned TMR_FIRST_BASE = 4;
  localparam int unsigned TMR_STRIDE     = 4;

  localparam int unsigned CTL_EN_BIT   = 0;
  localparam int unsigned CTL_AUTO_BIT = 1;

  localparam logic [15:0] CMD_SHUTDOWN = 16'h000E;

  typedef enum logic [1:0] {
    TREG_CTRL = 2'd0,
    TREG_CMP  = 2'd1,
    TREG_CNT  = 2'd2,
    TREG_NONE = 2'd3
  } tmr_reg_e;

  function automatic logic [IDX_W-1:0] word_slot(input logic [IDX_W+1:0] byte_addr);
    return byte_addr[IDX_W+1:2];
  endfunction

  function automatic logic is_shutdown_cmd(input logic [DATA_W-1:0] data);
    return data[15:0] == CMD_SHUTDOWN;
  endfunction

  function automatic logic [DATA_W-1:0] tmr_next(input logic [DATA_W-1:0] cnt,
                                                 input logic [DATA_W-1:0] cmp);
    return (cnt == cmp) ? '0 : cnt + 1'b1;
  endfunction

  function automatic tmr_reg_e tmr_decode(input logic [IDX_W-1:0] slot,
                                          input int unsigned base);
    logic [IDX_W-1:0] off;
    off = slot - IDX_W'(base);
    if (slot < IDX_W'(base) || off > 5'd2) return TREG_NONE;
    return tmr_reg_e'(off[1:0]);
  endfunction

endpackage

// File: rtl/soc_ctrl_timer.sv
module soc_ctrl_timer
  import soc_ctrl_pkg::*;
#(
  parameter int unsigned BASE = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  slot_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] cmp_o,
  output logic [DATA_W-1:0] cnt_o,
  output logic              irq_o
);

  tmr_reg_e          sel;
  logic              wr_ctrl, wr_cmp, wr_cnt;
  logic              en_q, auto_q, irq_q;
  logic [DATA_W-1:0] cmp_q, cnt_q;
  logic              hit;

  assign sel     = tmr_decode(slot_i, BASE);
  assign wr_ctrl = wr_en_i && (sel == TREG_CTRL);
  assign wr_cmp  = wr_en_i && (sel == TREG_CMP);
  assign wr_cnt  = wr_en_i && (sel == TREG_CNT);

  assign hit = en_q && (cnt_q == cmp_q) && !wr_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      auto_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q   <= wdata_i[CTL_EN_BIT];
      auto_q <= wdata_i[CTL_AUTO_BIT];
    end else if (hit && !auto_q) begin
      en_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cmp_q <= '0;
    else if (wr_cmp) cmp_q <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (wr_cnt) cnt_q <= wdata_i;
    else if (en_q)   cnt_q <= tmr_next(cnt_q, cmp_q);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= hit;
  end

  always_comb begin
    ctrl_o               = '0;
    ctrl_o[CTL_EN_BIT]   = en_q;
    ctrl_o[CTL_AUTO_BIT] = auto_q;
  end
  assign cmp_o = cmp_q;
  assign cnt_o = cnt_q;
  assign irq_o = irq_q;

  AST_ONESHOT_STOPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit && !auto_q && !wr_ctrl) |=> !en_q); // R9
  AST_HIT_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> irq_o); // R8
  AST_HIT_WRAPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> (cnt_q == '0)); // R8

endmodule

// File: rtl/soc_ctrl_gpio.sv
module soc_ctrl_gpio
  import soc_ctrl_pkg::*;
#(
  parameter int unsigned GPIO_W = 8,
  parameter logic [GPIO_W-1:0] STRAP = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_out_i,
  input  logic              wr_msk_i,
  input  logic [GPIO_W-1:0] wdata_i,
  input  logic [GPIO_W-1:0] pins_i,
  output logic [GPIO_W-1:0] in_o,
  output logic [GPIO_W-1:0] out_o,
  output logic [GPIO_W-1:0] msk_o,
  output logic              irq_o
);

  logic [GPIO_W-1:0] in_q, out_q, msk_q;
  logic [GPIO_W-1:0] changed;
  logic              irq_q;

  assign changed = (pins_i ^ in_q) & msk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      in_q  <= STRAP;
      out_q <= '0;
      msk_q <= '0;
      irq_q <= 1'b0;
    end else begin
      in_q  <= pins_i;
      irq_q <= |changed;
      if (wr_out_i) out_q <= wdata_i;
      if (wr_msk_i) msk_q <= wdata_i;
    end
  end

  assign in_o  = in_q;
  assign out_o = out_q;
  assign msk_o = msk_q;
  assign irq_o = irq_q;

  AST_GPIO_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (msk_q == '0) |=> !irq_o); // R12

endmodule

// File: rtl/soc_ctrl_dbg.sv
module soc_ctrl_dbg
  import soc_ctrl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_scratch_i,
  input  logic              wr_lock_i,
  input  logic              wr_cmd_i,
  input  logic              wr_id_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] scratch_o,
  output logic              lock_o,
  output logic              sys_reset_req_o,
  output logic              shutdown_req_o
);

  logic [DATA_W-1:0] scratch_q;
  logic              lock_q, rst_req_q, shut_req_q;
  logic              cmd_hit;

  assign cmd_hit = wr_cmd_i && is_shutdown_cmd(wdata_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scratch_q  <= '0;
      lock_q     <= 1'b0;
      rst_req_q  <= 1'b0;
      shut_req_q <= 1'b0;
    end else begin
      if (wr_scratch_i && !lock_q) scratch_q <= wdata_i;
      if (wr_lock_i) lock_q <= 1'b1;
      rst_req_q  <= wr_id_i;
      shut_req_q <= cmd_hit;
    end
  end

  assign scratch_o       = scratch_q;
  assign lock_o          = lock_q;
  assign sys_reset_req_o = rst_req_q;
  assign shutdown_req_o  = shut_req_q;

  AST_LOCK_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q); // R3
  AST_SCRATCH_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> $stable(scratch_q)); // R4
  AST_ID_WRITE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_id_i |=> sys_reset_req_o); // R5
  AST_SHUTDOWN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_hit |=> shutdown_req_o); // R6
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sys_reset_req_o, shutdown_req_o})); // R5

endmodule

// File: rtl/soc_ctrl_regs.sv
module soc_ctrl_regs
  import soc_ctrl_pkg::*;
#(
  parameter int unsigned       GPIO_W    = 8,
  parameter int unsigned       NUM_TMR   = 2,
  parameter logic [GPIO_W-1:0] GPIO_STRAP = 1,
  parameter logic [31:0]       SYS_ID    = 32'h10014D31,
  parameter logic [31:0]       CLK_HZ    = 32'd80000000,
  parameter logic [31:0]       CAPS      = 32'h0
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic               rd_en_i,
  input  logic [IDX_W+1:0]   addr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               rd_valid_o,
  input  logic [GPIO_W-1:0]  gpio_in_i,
  output logic [GPIO_W-1:0]  gpio_out_o,
  output logic               gpio_irq_o,
  output logic [NUM_TMR-1:0] tmr_irq_o,
  output logic               sys_reset_req_o,
  output logic               shutdown_req_o
);

  logic [IDX_W-1:0] slot;
  assign slot = word_slot(addr_i);

  // GPIO
  logic [GPIO_W-1:0] g_in, g_out, g_msk;

  soc_ctrl_gpio #(.GPIO_W(GPIO_W), .STRAP(GPIO_STRAP)) u_gpio (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_out_i (wr_en_i && slot == SLOT_GPIO_OUT),
    .wr_msk_i (wr_en_i && slot == SLOT_GPIO_MSK),
    .wdata_i  (wdata_i[GPIO_W-1:0]),
    .pins_i   (gpio_in_i),
    .in_o     (g_in),
    .out_o    (g_out),
    .msk_o    (g_msk),
    .irq_o    (gpio_irq_o)
  );
  assign gpio_out_o = g_out;

  // Timers
  logic [NUM_TMR-1:0][DATA_W-1:0] t_ctrl, t_cmp, t_cnt;

  for (genvar i = 0; i < NUM_TMR; i++) begin : g_tmr
    soc_ctrl_timer #(.BASE(TMR_FIRST_BASE + i * TMR_STRIDE)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_en_i (wr_en_i),
      .slot_i  (slot),
      .wdata_i (wdata_i),
      .ctrl_o  (t_ctrl[i]),
      .cmp_o   (t_cmp[i]),
      .cnt_o   (t_cnt[i]),
      .irq_o   (tmr_irq_o[i])
    );
  end

  // Debug, command port and request pulses
  logic [DATA_W-1:0] scratch;
  logic              lock;

  soc_ctrl_dbg u_dbg (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .wr_scratch_i    (wr_en_i && slot == SLOT_SCRATCH),
    .wr_lock_i       (wr_en_i && slot == SLOT_LOCK),
    .wr_cmd_i        (wr_en_i && slot == SLOT_CMD),
    .wr_id_i         (wr_en_i && slot == SLOT_ID),
    .wdata_i         (wdata_i),
    .scratch_o       (scratch),
    .lock_o          (lock),
    .sys_reset_req_o (sys_reset_req_o),
    .shutdown_req_o  (shutdown_req_o)
  );

  // Read mux
  logic [DATA_W-1:0] rd_mux;

  always_comb begin
    rd_mux = '0;
    unique case (slot)
      SLOT_GPIO_IN:  rd_mux = DATA_W'(g_in);
      SLOT_GPIO_OUT: rd_mux = DATA_W'(g_out);
      SLOT_GPIO_MSK: rd_mux = DATA_W'(g_msk);
      SLOT_CMD:      rd_mux = DATA_W'(1);
      SLOT_SCRATCH:  rd_mux = scratch;
      SLOT_LOCK:     rd_mux = DATA_W'(lock);
      SLOT_FREQ:     rd_mux = CLK_HZ;
      SLOT_CAPS:     rd_mux = CAPS;
      SLOT_ID:       rd_mux = SYS_ID;
      default:       rd_mux = '0;
    endcase
    for (int i = 0; i < NUM_TMR; i++) begin
      unique case (tmr_decode(slot, TMR_FIRST_BASE + i * TMR_STRIDE))
        TREG_CTRL: rd_mux = t_ctrl[i];
        TREG_CMP:  rd_mux = t_cmp[i];
        TREG_CNT:  rd_mux = t_cnt[i];
        default:   ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o    <= '0;
      rd_valid_o <= 1'b0;
    end else begin
      rd_valid_o <= rd_en_i;
      if (rd_en_i) rdata_o <= rd_mux;
    end
  end

  AST_READ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i |=> rd_valid_o); // R1
  AST_ID_CONSTANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && slot == SLOT_ID) |=> (rdata_o == SYS_ID)); // R5

endmodule

// File: tb/soc_ctrl_regs_bench.sv
module soc_ctrl_regs_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [6:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        rd_valid;
  logic [7:0]  pins = 8'h01;
  logic [7:0]  gout;
  logic        girq;
  logic [1:0]  tirq;
  logic        rreq, sreq;

  always #10 clk = ~clk;

  soc_ctrl_regs u_soc_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .rd_valid_o(rd_valid),
    .gpio_in_i(pins), .gpio_out_o(gout), .gpio_irq_o(girq),
    .tmr_irq_o(tirq), .sys_reset_req_o(rreq), .shutdown_req_o(sreq)
  );

  int n_vec = 0, n_bad = 0;
  bit done = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  int n_rreq = 0, n_sreq = 0, n_girq = 0, n_t0 = 0, n_t1 = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (rreq)    n_rreq++;
      if (sreq)    n_sreq++;
      if (girq)    n_girq++;
      if (tirq[0]) n_t0++;
      if (tirq[1]) n_t1++;
    end
  end

  // monitor: pop expected read data and compare
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      logic [31:0] e;
      string t;
      n_vec++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL %s unexpected read got %h expected none", "R1", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          n_bad++;
          $display("FAIL %s got %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr(input int slot, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = 7'(slot * 4); wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int byte_addr, input logic [31:0] e, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = 7'(byte_addr);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic chk(input int got, input int e, input string t);
    n_vec++;
    if (got != e) begin
      n_bad++;
      $display("FAIL %s got %0d expected %0d", t, got, e);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int gap;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R2 reset state
    rd(31*4, 32'h10014D31, "R2 id");
    rd(29*4, 32'd80000000, "R2 freq");
    rd(30*4, 32'h0, "R2 caps");
    rd(0, 32'h1, "R2 gpio in strap");
    rd(16*4, 32'h1, "R2 cmd ready");
    rd(21*4, 32'h0, "R2 lock");
    rd(20*4, 32'h0, "R2 scratch");
    rd(4*4, 32'h0, "R2 tmr0 ctrl");
    chk(int'(gout), 0, "R2 gpio_out port");

    // R1 decode, unmapped slots, aliasing of low bits
    rd(3*4, 32'h0, "R1 unmapped 3");
    wr(12, 32'hFFFF_FFFF);
    rd(12*4, 32'h0, "R1 unmapped write 12");
    rd(25*4 + 2, 32'h0, "R1 unmapped 25");
    rd(31*4 + 3, 32'h10014D31, "R1 low bits ignored");

    // R7 read-only words
    wr(29, 32'h0);
    wr(30, 32'h5);
    wr(0, 32'hFF);
    rd(29*4, 32'd80000000, "R7 freq");
    rd(30*4, 32'h0, "R7 caps");
    rd(0, 32'h1, "R7 gpio in");

    // R11 gpio out and mask
    wr(1, 32'h1A5);
    rd(1*4, 32'hA5, "R11 gpio out");
    chk(int'(gout), 32'hA5, "R11 gpio_out port");
    wr(2, 32'h04);
    rd(2*4, 32'h04, "R11 mask");

    // R12 gpio change interrupt
    n_girq = 0;
    @(negedge clk); pins = 8'h05;
    repeat (3) @(negedge clk);
    chk(n_girq, 1, "R12 enabled bit change");
    pins = 8'h04;
    repeat (3) @(negedge clk);
    chk(n_girq, 1, "R12 masked bit change");

    // R4 / R3 scratch and lock
    wr(20, 32'hDEADBEEF);
    rd(20*4, 32'hDEADBEEF, "R4 scratch unlocked");
    wr(21, 32'h0);
    rd(21*4, 32'h1, "R3 lock set by zero write");
    wr(20, 32'h1234);
    rd(20*4, 32'hDEADBEEF, "R4 scratch locked");
    wr(21, 32'h0);
    rd(21*4, 32'h1, "R3 lock stays");

    // R5 identity write
    n_rreq = 0;
    wr(31, 32'h0);
    repeat (2) @(negedge clk);
    chk(n_rreq, 1, "R5 reset request pulse");
    rd(31*4, 32'h10014D31, "R5 id unchanged");

    // R6 command port
    n_sreq = 0;
    wr(16, 32'hABCD000E);
    repeat (2) @(negedge clk);
    chk(n_sreq, 1, "R6 shutdown code");
    wr(16, 32'h0000000F);
    wr(16, 32'h000E0000);
    repeat (2) @(negedge clk);
    chk(n_sreq, 1, "R6 other codes");
    rd(16*4, 32'h1, "R6 ready readback");

    // R8 stopped counter holds
    wr(6, 32'd7);
    repeat (3) @(negedge clk);
    rd(6*4, 32'd7, "R8 stopped counter");

    // R9 one-shot on timer 0
    n_t0 = 0;
    wr(5, 32'd3);
    wr(6, 32'd0);
    wr(4, 32'h1);
    repeat (20) @(negedge clk);
    chk(n_t0, 1, "R9 single pulse");
    rd(4*4, 32'h0, "R9 enable cleared");
    rd(6*4, 32'h0, "R9 counter at zero");
    rd(5*4, 32'd3, "R8 compare readback");

    // R10 auto-restart on timer 1 (R8 timer 1 window)
    wr(9, 32'd4);
    wr(10, 32'd0);
    wr(8, 32'h3);
    rd(8*4, 32'h3, "R8 tmr1 ctrl");
    gap = 0;
    while (!tirq[1] && gap < 50) begin @(negedge clk); gap++; end
    gap = 0;
    @(negedge clk);
    gap = 1;
    while (!tirq[1] && gap < 50) begin @(negedge clk); gap++; end
    chk(gap, 5, "R10 restart period");
    wr(8, 32'h0);
    chk(n_t0, 1, "R8 timer0 unaffected by timer1");

    repeat (4) @(negedge clk);
    chk(exp_q.size(), 0, "R1 all reads answered");
    finish_run();
  end

endmodule